// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block makes the serial clock for an I2C master. Software places a 7-bit divider value in an 8-bit rate register and then writes a byte to the transmit data buffer. That buffer write starts a down counter, which is loaded from the divider. The counter advances on two phase strobes in each instruction cycle, so it runs at twice the instruction rate. Each time it reaches zero it reloads and flips SCL.

Two counter rollovers make one SCL period, so SCL runs at the instruction rate divided by (divider + 1). For example, a 10 MHz instruction rate with a divider of 24 gives 400 kHz. After nine SCL pulses (eight data bits and the acknowledge clock) the block stops by itself. SCL then stays at its final level, which is high, until the next buffer write.

The enable input acts as the clock supply to the counter. While enable is low, for instance in a sleep state, nothing advances.

Top module: `scl_rate_gen`

## Requirements
- R1: During and right after a synchronous reset, `scl` is 1, `busy` is 0 and `tick` is 0.
- R2: The divider is `rate_reg[6:0]`. Bit 7 of `rate_reg` has no effect, so 0x83 gives the same timing as 0x03.
- R3: A `buf_wr` pulse seen at a clock edge while `en` is 1 and `busy` is 0 latches the divider and sets `busy` 1 after that edge.
- R4: The counter moves one step only at an edge where `en` is 1 and either `phase_a` or `phase_b` is 1. At every other edge it holds.
- R5: A rollover happens on every (divider + 1)-th step. At a rollover, `scl` inverts and `tick` is 1 for exactly that cycle. With one step every two clocks, each SCL level lasts 2*(divider + 1) clocks.
- R6: A divider of 0 inverts `scl` on every step, and no toggle is missed.
- R7: A transfer has 18 toggles, which make 9 low pulses. The first toggle drives `scl` low. `busy` drops at the same edge as the ninth rising edge, and `scl` ends high.
- R8: A `buf_wr` while `busy` is 1 has no effect on the divider in use, on the pulse count or on the timing.
- R9: While `en` is 0, `scl` and the counter are frozen, `tick` stays 0, and a `buf_wr` does not start a transfer.
- R10: While idle, `scl` stays 1 and `tick` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counter clock supply enable |
| phase_a | input | 1 | First counting phase strobe of each instruction cycle |
| phase_b | input | 1 | Second counting phase strobe of each instruction cycle |
| rate_reg | input | 8 | Rate register. Bits 6:0 are the divider. |
| buf_wr | input | 1 | Transmit buffer write strobe |
| scl | output | 1 | Serial clock, idles high |
| tick | output | 1 | One-cycle pulse at each SCL toggle |
| busy | output | 1 | High from buffer write until automatic stop |

## Verification
A wrong count or reload in the counter shows up at the first toggle as a half period on `scl` that differs from 2*(divider + 1) clocks. It also changes the length of `busy` by a predictable amount. A wrong edge counter shows up at the end of the transfer, in the number of low pulses, the final SCL level, or the cycle in which `busy` drops. A broken enable or busy guard shows up within one step: `scl` moves during a freeze, or a transfer restarts or retimes after an ignored write.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    localparam int unsigned DEF_REG_W     = 8;
    localparam int unsigned DEF_RELOAD_W  = 7;
    localparam int unsigned DEF_DATA_BITS = 8;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Each SCL pulse has a falling and a rising toggle; acknowledge adds one pulse.
    function automatic int unsigned edges_per_xfer(input int unsigned data_bits);
        return 2 * (data_bits + 1);
    endfunction

    function automatic int unsigned width_for(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/scl_ctrl_gate.sv
module scl_ctrl_gate (
    input  logic en,
    input  logic phase_a,
    input  logic phase_b,
    input  logic buf_wr,
    input  logic busy,
    output logic step,
    output logic start
);
    always_comb begin
        step  = en & (phase_a | phase_b);
        start = en & buf_wr & ~busy;
    end
endmodule

// File: rtl/scl_down_counter.sv
module scl_down_counter #(
    parameter int unsigned CW = scl_gen_pkg::DEF_RELOAD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          step,
    input  logic          run,
    input  logic [CW-1:0] reload_in,
    output logic          rollover
);
    typedef struct packed {
        logic [CW-1:0] rel;
        logic [CW-1:0] cnt;
    } cnt_state_t;

    localparam logic [CW-1:0] ONE = CW'(1);

    cnt_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        rollover = run & step & (st_q.cnt == '0);
        if (start) begin
            st_d.rel = reload_in;
            st_d.cnt = reload_in;
        end else if (run && step) begin
            st_d.cnt = rollover ? st_q.rel : (st_q.cnt - ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assert_cnt_within_reload_R5: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= st_q.rel);

    assert_hold_without_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!step && !start) |=> $stable(st_q.cnt));

    assert_reload_after_rollover_R5: assert property (@(posedge clk) disable iff (rst)
        rollover |=> (st_q.cnt == st_q.rel));

    assert_divider_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (run && !start) |=> $stable(st_q.rel));
endmodule

// File: rtl/scl_edge_seq.sv
module scl_edge_seq #(
    parameter int unsigned EDGES = scl_gen_pkg::edges_per_xfer(scl_gen_pkg::DEF_DATA_BITS)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rollover,
    output logic scl,
    output logic busy,
    output logic tick
);
    import scl_gen_pkg::*;

    localparam int unsigned EW = width_for(EDGES);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

    typedef struct packed {
        seq_state_e    st;
        logic          scl;
        logic          tick;
        logic [EW-1:0] ecnt;
    } seq_state_t;

    seq_state_t q, d;

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        if (start) begin
            d.st   = SEQ_RUN;
            d.scl  = 1'b1;
            d.ecnt = '0;
        end else if (rollover) begin
            d.scl  = ~q.scl;
            d.tick = 1'b1;
            if (q.ecnt == LAST_EDGE) begin
                d.st   = SEQ_IDLE;
                d.ecnt = '0;
            end else begin
                d.ecnt = q.ecnt + EW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st   <= SEQ_IDLE;
            q.scl  <= 1'b1;
            q.tick <= 1'b0;
            q.ecnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign scl  = q.scl;
    assign busy = (q.st == SEQ_RUN);
    assign tick = q.tick;

    assert_idle_scl_high_R10: assert property (@(posedge clk) disable iff (rst)
        (q.st == SEQ_IDLE) |-> q.scl);

    assert_edge_bound_R7: assert property (@(posedge clk) disable iff (rst)
        q.ecnt <= LAST_EDGE);

    assert_done_on_high_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> scl);

    assert_first_edge_low_R7: assert property (@(posedge clk) disable iff (rst)
        (q.st == SEQ_RUN && q.ecnt == '0 && rollover && !start) |=> !q.scl);
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
    parameter int unsigned REG_W     = scl_gen_pkg::DEF_REG_W,
    parameter int unsigned RELOAD_W  = scl_gen_pkg::DEF_RELOAD_W,
    parameter int unsigned DATA_BITS = scl_gen_pkg::DEF_DATA_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic [REG_W-1:0] rate_reg,
    input  logic             buf_wr,
    output logic             scl,
    output logic             tick,
    output logic             busy
);
    localparam int unsigned EDGES = scl_gen_pkg::edges_per_xfer(DATA_BITS);

    logic step, start, rollover;
    logic unused_rate_hi;

    assign unused_rate_hi = ^rate_reg[REG_W-1:RELOAD_W];

    scl_ctrl_gate u_gate (
        .en      (en),
        .phase_a (phase_a),
        .phase_b (phase_b),
        .buf_wr  (buf_wr),
        .busy    (busy),
        .step    (step),
        .start   (start)
    );

    scl_down_counter #(.CW(RELOAD_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .step      (step),
        .run       (busy),
        .reload_in (rate_reg[RELOAD_W-1:0]),
        .rollover  (rollover)
    );

    scl_edge_seq #(.EDGES(EDGES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rollover (rollover),
        .scl      (scl),
        .busy     (busy),
        .tick     (tick)
    );

    assert_tick_marks_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (scl != $past(scl)) |-> tick);

    assert_start_needs_write_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(en && buf_wr));

    assert_frozen_when_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(scl) && !tick && $stable(busy)));
endmodule

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b1;
    logic phase_a, phase_b;
    logic [7:0] rate_reg = 8'h00;
    logic buf_wr = 1'b0;
    logic scl, tick, busy;

    logic [1:0] qph = 2'd0;
    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    int m_busy, m_falls, m_rises, m_ticks, m_bad_iv, m_first, m_tick_bad, m_stall_bad;
    logic m_end_scl;

    always #2.5 clk = ~clk;

    always @(posedge clk) qph <= qph + 2'd1;
    assign phase_a = (qph == 2'd1);
    assign phase_b = (qph == 2'd3);

    scl_rate_gen dut (
        .clk(clk), .rst(rst), .en(en), .phase_a(phase_a), .phase_b(phase_b),
        .rate_reg(rate_reg), .buf_wr(buf_wr), .scl(scl), .tick(tick), .busy(busy)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Starts a transfer aligned to the phase counter and measures it at the ports.
    task automatic run_xfer(input logic [7:0] rv, input int iv_exp,
                            input int stall_at, input int stall_len, input int mid_wr_at);
        int n;
        int last;
        logic prev;
        m_busy = 0; m_falls = 0; m_rises = 0; m_ticks = 0; m_bad_iv = 0;
        m_first = -1; m_tick_bad = 0; m_stall_bad = 0;
        do @(negedge clk); while (qph != 2'd0);
        rate_reg = rv;
        buf_wr = 1'b1;
        prev = scl;
        last = -1;
        n = 0;
        while (n < 20000) begin
            @(negedge clk);
            buf_wr = 1'b0;
            if (n == mid_wr_at) begin
                buf_wr = 1'b1;
                rate_reg = 8'h00;
            end
            if (stall_len > 0 && n > stall_at && n <= stall_at + stall_len) begin
                if (scl != prev || tick) m_stall_bad++;
            end
            if (tick) m_ticks++;
            if (scl != prev) begin
                if (!tick) m_tick_bad++;
                if (scl == 1'b0) m_falls++; else m_rises++;
                if (stall_len == 0 && last >= 0 && (n - last) != iv_exp) m_bad_iv++;
                if (m_first < 0) m_first = n;
                last = n;
            end
            prev = scl;
            if (stall_len > 0 && n == stall_at) en = 1'b0;
            if (stall_len > 0 && n == stall_at + stall_len) en = 1'b1;
            if (!busy) break;
            m_busy++;
            n++;
        end
        buf_wr = 1'b0;
        en = 1'b1;
        m_end_scl = scl;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(scl == 1'b1, "R1 scl in reset", scl, 1);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        check(tick == 1'b0 && scl == 1'b1, "R1 after reset", {tick, scl}, 1);
    endtask

    task automatic t_idle();
        int bad;
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (!scl || tick || busy) bad++;
        end
        check(bad == 0, "R10 idle outputs", bad, 0);
        en = 1'b0;
        rate_reg = 8'h05;
        buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (busy || !scl || tick) bad++;
        end
        en = 1'b1;
        check(bad == 0, "R9 write ignored while disabled", bad, 0);
    endtask

    task automatic t_rate(input logic [7:0] rv, input int dv, input string tag);
        int h;
        h = 2 * (dv + 1);
        run_xfer(rv, h, -1, 0, -1);
        check(m_busy == 18 * h - 1, {tag, " busy length"}, m_busy, 18 * h - 1);
        check(m_first == h - 1, {tag, " first toggle"}, m_first, h - 1);
        check(m_bad_iv == 0, {tag, " half period (R4)"}, m_bad_iv, 0);
        check(m_falls == 9 && m_rises == 9, "R7 nine pulses", m_falls * 100 + m_rises, 909);
        check(m_ticks == 18 && m_tick_bad == 0, "R5 tick per toggle", m_ticks, 18);
        check(m_end_scl == 1'b1, "R7 ends high", m_end_scl, 1);
    endtask

    task automatic t_busy_write();
        run_xfer(8'h09, 20, -1, 0, 30);
        check(m_busy == 359, "R8 busy write ignored length", m_busy, 359);
        check(m_bad_iv == 0, "R8 busy write ignored timing", m_bad_iv, 0);
        check(m_falls == 9, "R8 pulse count", m_falls, 9);
    endtask

    task automatic t_stall();
        run_xfer(8'h09, 20, 50, 24, -1);
        check(m_stall_bad == 0, "R9 frozen while disabled", m_stall_bad, 0);
        check(m_busy == 359 + 24, "R9 stall delays completion", m_busy, 383);
        check(m_falls == 9 && m_end_scl == 1'b1, "R9 R7 pulses after stall", m_falls, 9);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_rate(8'h18, 24, "R5 R3 divider 24");
        t_rate(8'h00, 0, "R6 divider 0");
        t_rate(8'h83, 3, "R2 bit7 ignored");
        t_rate(8'h03, 3, "R2 divider 3");
        t_busy_write();
        t_stall();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule